// File: doc/BRIEF.md
# Address-Masked GPIO Port

An eight-line general-purpose I/O port that sits on an APB slave interface. It holds an output data register and a direction register. It drives a per-pin output enable and output value, and it samples the external pin levels through a two-flop synchronizer.

The data register is reached through a window of 256 word addresses. Address bits [9:2] of each access act as a per-pin mask. A write changes only the pins whose mask bit is set, so software can set or clear one pin with a single store and no read-modify-write. A read returns zero in every unmasked bit. For example, the address `1 << (n+2)` selects pin n alone. The direction register sits just above the window at offset 0x400.

Every transfer completes with zero wait states. There is no error response. Offsets outside the two registers read as zero and ignore writes.

Top module: `apb_gpio_port`

## Requirements
- R1: After reset, the direction register and the output data register are 0. So `pin_oe_o` and `pin_o` are both 0x00 and every pin is an input.
- R2: A completed APB write (psel, penable and pwrite all high) to an offset below 0x400 loads bit n of the output data register from `pwdata_i[n]` only where `paddr_i[n+2]` is 1. Every other bit keeps its value.
- R3: A read at an offset below 0x400 returns 0 in every bit n where `paddr_i[n+2]` is 0, whatever the pin or register state.
- R4: In a masked-in bit of a data read, a pin whose direction bit is 1 returns its output data register bit. A pin whose direction bit is 0 returns its synchronized external input.
- R5: Offset 0x400 is the direction register. A completed write loads all 8 bits from `pwdata_i`, and a read returns them. Bit n set to 1 makes pin n an output.
- R6: `pin_oe_o[n]` equals direction bit n, and `pin_o[n]` equals output data register bit n, from the clock edge that completes the write onward.
- R7: A change on `pin_i` first appears in a data read after exactly two rising clock edges. It does not appear after one.
- R8: `pready_o` is always 1 and `pslverr_o` is always 0.
- R9: Reads of any offset from 0x404 upward return 0. Writes there change neither register.
- R10: A setup-phase cycle (psel high, penable low) with pwrite high changes neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB access phase |
| pwrite_i | input | 1 | APB write (1) or read (0) |
| paddr_i | input | 12 | APB byte address; bits [9:2] are the data mask |
| pwdata_i | input | 8 | APB write data |
| prdata_o | output | 8 | APB read data, valid while psel_i is high |
| pready_o | output | 1 | APB ready, tied high |
| pslverr_o | output | 1 | APB error, tied low |
| pin_i | input | 8 | External pin levels, asynchronous |
| pin_o | output | 8 | Pin output values |
| pin_oe_o | output | 8 | Pin output enables |

## Verification
The hardest behaviour to reach from the ports is the latency of the synchronizer. An ordinary APB read spans several edges and hides whether the input took one stage or two. The stimulus therefore holds a read of the full-mask data address in its setup phase, with psel high and penable low, so that `prdata_o` follows the synchronized input from cycle to cycle. It then moves `pin_i` on a falling edge and samples one and two edges later. The masked write and masked read paths are each swept over all 256 masks, with mixed direction patterns, so that every combination of mask, direction and source is met.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_NONE = 2'd2
  } gpio_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= async_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int unsigned NPINS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             data_we_i,
  input  logic             dir_we_i,
  input  logic [NPINS-1:0] mask_i,
  input  logic [NPINS-1:0] wdata_i,
  output logic [NPINS-1:0] dout_o,
  output logic [NPINS-1:0] dir_o
);
  logic [NPINS-1:0] dout_q, dir_q;

  // masked per-bit update: unmasked bits hold
  for (genvar i = 0; i < NPINS; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) dout_q[i] <= 1'b0;
      else if (data_we_i && mask_i[i]) dout_q[i] <= wdata_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dir_q <= '0;
    else if (dir_we_i) dir_q <= wdata_i;
  end

  assign dout_o = dout_q;
  assign dir_o  = dir_q;
endmodule

// File: rtl/gpio_rdmux.sv
module gpio_rdmux
  import gpio_pkg::*;
#(
  parameter int unsigned NPINS = 8
) (
  input  gpio_sel_e        sel_i,
  input  logic [NPINS-1:0] mask_i,
  input  logic [NPINS-1:0] dout_i,
  input  logic [NPINS-1:0] dir_i,
  input  logic [NPINS-1:0] pin_sync_i,
  output logic [NPINS-1:0] rdata_o
);
  logic [NPINS-1:0] level;

  assign level = (dir_i & dout_i) | (~dir_i & pin_sync_i);

  always_comb begin
    unique case (sel_i)
      SEL_DATA: rdata_o = level & mask_i;
      SEL_DIR:  rdata_o = dir_i;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/apb_gpio_port.sv
module apb_gpio_port
  import gpio_pkg::*;
#(
  parameter int unsigned NPINS       = 8,
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [NPINS-1:0]  pwdata_i,
  output logic [NPINS-1:0]  prdata_o,
  output logic              pready_o,
  output logic              pslverr_o,
  input  logic [NPINS-1:0]  pin_i,
  output logic [NPINS-1:0]  pin_o,
  output logic [NPINS-1:0]  pin_oe_o
);
  localparam int unsigned WA_W    = ADDR_W - 2;
  localparam logic [WA_W-1:0] DIR_WA = WA_W'(1 << NPINS);

  gpio_sel_e        sel;
  logic [NPINS-1:0] mask, dout, dir, pin_sync, rdata;
  logic             wr_acc;

  assign mask   = paddr_i[NPINS+1:2];
  assign wr_acc = psel_i && penable_i && pwrite_i;

  always_comb begin
    if (paddr_i[ADDR_W-1:NPINS+2] == '0) sel = SEL_DATA;
    else if (paddr_i[ADDR_W-1:2] == DIR_WA) sel = SEL_DIR;
    else sel = SEL_NONE;
  end

  gpio_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (pin_i),
    .sync_o  (pin_sync)
  );

  gpio_regs #(.NPINS(NPINS)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .data_we_i (wr_acc && (sel == SEL_DATA)),
    .dir_we_i  (wr_acc && (sel == SEL_DIR)),
    .mask_i    (mask),
    .wdata_i   (pwdata_i),
    .dout_o    (dout),
    .dir_o     (dir)
  );

  gpio_rdmux #(.NPINS(NPINS)) u_rdmux (
    .sel_i      (sel),
    .mask_i     (mask),
    .dout_i     (dout),
    .dir_i      (dir),
    .pin_sync_i (pin_sync),
    .rdata_o    (rdata)
  );

  assign prdata_o  = psel_i ? rdata : '0;
  assign pready_o  = 1'b1;
  assign pslverr_o = 1'b0;
  assign pin_o     = dout;
  assign pin_oe_o  = dir;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int unsigned NPINS  = 8,
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              psel_i,
  input logic              penable_i,
  input logic              pwrite_i,
  input logic [ADDR_W-1:0] paddr_i,
  input logic [NPINS-1:0]  pwdata_i,
  input logic [NPINS-1:0]  prdata_o,
  input logic              pready_o,
  input logic              pslverr_o,
  input logic [NPINS-1:0]  pin_o,
  input logic [NPINS-1:0]  pin_oe_o
);
  logic [NPINS-1:0] m;
  logic             in_data, in_dir, wr;

  assign m       = paddr_i[NPINS+1:2];
  assign in_data = paddr_i[ADDR_W-1:NPINS+2] == '0;
  assign in_dir  = paddr_i == ADDR_W'(1 << (NPINS + 2));
  assign wr      = psel_i && penable_i && pwrite_i;

  AST_READY_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pready_o && !pslverr_o); // R8

  AST_MASK_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && in_data) |=> ((pin_o & $past(m)) == ($past(pwdata_i) & $past(m)))); // R2

  AST_UNMASKED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && in_data) |=> ((pin_o & ~$past(m)) == ($past(pin_o) & ~$past(m)))); // R2

  AST_READ_MASKED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_i && !pwrite_i && in_data) |-> ((prdata_o & ~m) == '0)); // R3

  AST_DIR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && in_dir) |=> (pin_oe_o == $past(pwdata_i))); // R5

  AST_NO_ACCESS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr |=> ($stable(pin_o) && $stable(pin_oe_o))); // R10

  AST_UNMAPPED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && !in_data && !in_dir) |=> ($stable(pin_o) && $stable(pin_oe_o))); // R9
endmodule

bind apb_gpio_port gpio_port_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .psel_i    (psel_i),
  .penable_i (penable_i),
  .pwrite_i  (pwrite_i),
  .paddr_i   (paddr_i),
  .pwdata_i  (pwdata_i),
  .prdata_o  (prdata_o),
  .pready_o  (pready_o),
  .pslverr_o (pslverr_o),
  .pin_o     (pin_o),
  .pin_oe_o  (pin_oe_o)
);

// File: tb/sim_apb_gpio_port.sv
`timescale 1ns/1ps
module sim_apb_gpio_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [7:0]  pwdata = '0, prdata, pin_in = '0, pin_out, pin_oe;
  logic        pready, pslverr;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  apb_gpio_port u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .psel_i    (psel),
    .penable_i (penable),
    .pwrite_i  (pwrite),
    .paddr_i   (paddr),
    .pwdata_i  (pwdata),
    .prdata_o  (prdata),
    .pready_o  (pready),
    .pslverr_o (pslverr),
    .pin_i     (pin_in),
    .pin_o     (pin_out),
    .pin_oe_o  (pin_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apb_write(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_read(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    #1;
    d = prdata;
    chk("R8 ready/err", {6'd0, pready, pslverr}, 8'h02);
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [7:0] dout_m, dir_m, rd, exp;
    repeat (3) @(negedge clk);
    chk("R1 reset pin_o", pin_out, 8'h00);
    chk("R1 reset pin_oe", pin_oe, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release pin_oe", pin_oe, 8'h00);
    apb_read(12'h400, rd);
    chk("R1 dir read", rd, 8'h00);

    // R2/R6: exhaustive masked write sweep
    dout_m = 8'h00;
    for (int m = 0; m < 256; m++) begin
      logic [7:0] d;
      d = 8'((m * 37 + 11) & 255);
      apb_write(12'(m << 2), d);
      dout_m = (dout_m & ~8'(m)) | (d & 8'(m));
      chk("R2 masked write", pin_out, dout_m);
    end

    // R5/R6: direction register
    apb_write(12'h400, 8'hA5);
    chk("R6 oe follows dir", pin_oe, 8'hA5);
    apb_read(12'h400, rd);
    chk("R5 dir readback", rd, 8'hA5);
    dir_m = 8'hA5;

    // single-pin set/clear via one-hot address
    apb_write(12'h3FC, 8'h00);
    dout_m = 8'h00;
    for (int n = 0; n < 8; n++) begin
      apb_write(12'(1 << (n + 2)), 8'hFF);
      dout_m[n] = 1'b1;
      chk("R2 single pin set", pin_out, dout_m);
    end
    for (int n = 0; n < 8; n += 2) begin
      apb_write(12'(1 << (n + 2)), 8'h00);
      dout_m[n] = 1'b0;
      chk("R2 single pin clear", pin_out, dout_m);
    end

    // R3/R4: exhaustive masked read sweep, two configurations
    apb_write(12'h3FC, 8'h69);
    dout_m = 8'h69;
    pin_in = 8'h3C;
    repeat (3) @(negedge clk);
    for (int m = 0; m < 256; m++) begin
      apb_read(12'(m << 2), rd);
      exp = 8'(m) & ((dir_m & dout_m) | (~dir_m & pin_in));
      chk("R3/R4 masked read", rd, exp);
    end
    apb_write(12'h400, 8'h0F);
    dir_m = 8'h0F;
    pin_in = 8'hC3;
    repeat (3) @(negedge clk);
    for (int m = 0; m < 256; m++) begin
      apb_read(12'(m << 2 | (m & 3)), rd);
      exp = 8'(m) & ((dir_m & dout_m) | (~dir_m & pin_in));
      chk("R3/R4 masked read alt", rd, exp);
    end

    // R7: synchronizer latency, held setup phase
    apb_write(12'h400, 8'h00);
    pin_in = 8'h00;
    repeat (3) @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = 12'h3FC;
    @(negedge clk);
    chk("R7 baseline", prdata, 8'h00);
    pin_in = 8'h96;
    @(negedge clk);
    chk("R7 one edge not yet", prdata, 8'h00);
    @(negedge clk);
    chk("R7 two edges visible", prdata, 8'h96);
    psel = 1'b0;

    // R10: setup-only write cycles
    apb_write(12'h3FC, 8'h5A);
    apb_write(12'h400, 8'h33);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = 12'h3FC; pwdata = 8'hFF;
    @(negedge clk);
    paddr = 12'h400;
    @(negedge clk);
    psel = 1'b0; pwrite = 1'b0;
    chk("R10 data held", pin_out, 8'h5A);
    chk("R10 dir held", pin_oe, 8'h33);

    // R9: unmapped offsets
    apb_write(12'h404, 8'hFF);
    apb_write(12'h800, 8'h00);
    apb_write(12'hFFC, 8'hFF);
    chk("R9 data untouched", pin_out, 8'h5A);
    chk("R9 dir untouched", pin_oe, 8'h33);
    apb_read(12'h404, rd);
    chk("R9 read 0x404", rd, 8'h00);
    apb_read(12'h800, rd);
    chk("R9 read 0x800", rd, 8'h00);
    apb_read(12'hFFC, rd);
    chk("R9 read 0xFFC", rd, 8'h00);

    // R1: reset mid-run clears both registers
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 re-reset pin_o", pin_out, 8'h00);
    chk("R1 re-reset pin_oe", pin_oe, 8'h00);
    rst_n = 1'b1;

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule